// File: doc/BRIEF.md
# Synchronous Serial Port Register and Interrupt Unit

This block is the processor-facing side of a synchronous serial port master. A simple memory bus (byte address, write data with byte-lane strobes, registered read data) reaches six word-aligned registers: two control words, a data port, a status word, a clock prescale value and a shared interrupt status/clear word. Frames written to the data port queue in an 8-deep transmit FIFO. Frames coming back from the serial side queue in an 8-deep receive FIFO, which the data port drains on read.

The serial shifter itself lies outside this unit. Inside, a timing model stands in for it. That model takes one frame from the transmit FIFO and holds it for a fixed number of cycles. It then returns either the same frame (loopback) or the word present on `far_rx_word`, cut to the configured frame size. Three interrupt sources are combined into one maskable interrupt line: a receive threshold, a transmit threshold and a sticky receive overrun.

Top module: `ssp_regif`

## Requirements
- R1: After synchronous reset, control 0, control 1, prescale and read data are zero. Status reads 0x0003 (transmit empty and transmit not full). Interrupt status reads 0x0002 and `irq` is low.
- R2: Word offsets are 0x00 control 0 (16 bits), 0x04 control 1 (7 bits: bit0 receive irq enable, bit1 transmit irq enable, bit2 overrun irq enable, bit3 loopback, bit4 port enable, bit5 master/slave select, bit6 slave output disable), 0x08 data, 0x0C status, 0x10 prescale and 0x14 interrupt status/clear. A write updates only the byte lanes whose strobe is set (`bus_be[0]` bits 7:0, `bus_be[1]` bits 15:8). Read data appears the cycle after `bus_rd`.
- R3: The prescale register holds 8 bits and always reads with bit 0 cleared (only even divisors).
- R4: A write to the data offset pushes one frame (unstrobed lanes zero) into the transmit FIFO. A write when that FIFO holds 8 frames is dropped.
- R5: A read of the data offset returns and removes the oldest received frame. A read of an empty receive FIFO returns 0 and changes nothing.
- R6: Status bits are: bit0 transmit FIFO empty, bit1 transmit FIFO not full, bit2 receive FIFO not empty, bit3 receive FIFO full, bit4 busy (a frame is in the shifter).
- R7: Control 0 bits 3:0 hold the frame size minus one (3 to 15). Each received frame is masked to that many bits plus one. With loopback set the frame returned is the transmitted one, otherwise it is `far_rx_word`.
- R8: While port enable is clear, no frame leaves the transmit FIFO and both FIFOs keep their contents. Setting it again resumes transfers in order.
- R9: Interrupt status bit1 (transmit request) is set while the transmit FIFO holds at most 4 frames. Bit0 (receive request) is set while the receive FIFO holds at least 4 frames.
- R10: A frame delivered while the receive FIFO is full is dropped and sets interrupt status bit2, which stays set until any write to offset 0x14 clears it.
- R11: `irq` is high exactly when some interrupt status bit and its control 1 enable bit (bits 2:0, same order) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| far_rx_word | input | 16 | Word returned by the serial side when loopback is off |
| irq | output | 1 | Combined masked interrupt |

## Verification
On every cycle, the assertions check the following: no write past a full transmit FIFO, receive-FIFO pops, the conditions under which overrun may rise or must clear, that a dropped frame never enters the receive FIFO, the idle hold while the port is disabled, the even prescale and a silent `irq` with all enables clear. Only the bench scenarios can show the data itself. This covers frame ordering through both FIFOs, masking across every frame size, the threshold flags at every fill level, byte-lane writes and the mapping of each enable to `irq`.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W = 16;
    localparam int LANES  = WORD_W / 8;
    localparam int SIZE_W = 4;

    // word index of each register (byte offset / 4)
    localparam logic [2:0] IDX_CTRL0 = 3'd0;
    localparam logic [2:0] IDX_CTRL1 = 3'd1;
    localparam logic [2:0] IDX_DATA  = 3'd2;
    localparam logic [2:0] IDX_STAT  = 3'd3;
    localparam logic [2:0] IDX_PRESC = 3'd4;
    localparam logic [2:0] IDX_ISR   = 3'd5;

    typedef struct packed {
        logic slave_out_off;
        logic slave_sel;
        logic port_on;
        logic loop_back;
        logic ovr_ie;
        logic txq_ie;
        logic rxq_ie;
    } ctrl1_t;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_some;
        logic tx_room;
        logic tx_empty;
    } stat_t;

    typedef struct packed {
        logic ovr;
        logic txq;
        logic rxq;
    } isr_t;

    typedef enum logic {SH_IDLE, SH_RUN} shift_st_t;

    function automatic logic [WORD_W-1:0] size_mask(input logic [SIZE_W-1:0] size_m1);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i <= int'(size_m1));
        end
        return m;
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ssp_shift_model.sv
module ssp_shift_model
    import ssp_pkg::*;
#(
    parameter int XFER_CYCLES = 6,
    localparam int CYC_W = $clog2(XFER_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              loopback,
    input  logic [SIZE_W-1:0] size_m1,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_head,
    input  logic              rx_full,
    input  logic [WORD_W-1:0] far_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              overrun_evt,
    output logic              busy
);
    localparam logic [CYC_W-1:0] LOAD = CYC_W'(XFER_CYCLES - 1);

    shift_st_t        st;
    logic [CYC_W-1:0] cyc;
    logic [WORD_W-1:0] held;
    logic done;

    assign tx_pop      = (st == SH_IDLE) && enable && !tx_empty;
    assign done        = (st == SH_RUN) && (cyc == '0);
    assign rx_word     = (loopback ? held : far_word) & size_mask(size_m1);
    assign rx_push     = done && !rx_full;
    assign overrun_evt = done && rx_full;
    assign busy        = (st == SH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SH_IDLE;
            cyc  <= '0;
            held <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (tx_pop) begin
                        held <= tx_head;
                        cyc  <= LOAD;
                        st   <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    if (cyc == '0) begin
                        st <= SH_IDLE;
                    end else begin
                        cyc <= cyc - 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ssp_irq_ctl.sv
module ssp_irq_ctl
    import ssp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             overrun_evt,
    input  logic             clear,
    input  isr_t             enables,
    output isr_t             raw,
    output logic             ovr_flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_flag <= 1'b0;
        end else if (overrun_evt) begin
            ovr_flag <= 1'b1;
        end else if (clear) begin
            ovr_flag <= 1'b0;
        end
    end

    always_comb begin
        raw.rxq = (rx_count >= HALF);
        raw.txq = (tx_count <= HALF);
        raw.ovr = ovr_flag;
        irq     = |(raw & enables);
    end
endmodule

// File: rtl/ssp_regif.sv
module ssp_regif
    import ssp_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int FIFO_DEPTH  = 8,
    parameter int XFER_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [LANES-1:0]  bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] far_rx_word,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    // decode
    logic       aligned;
    logic [2:0] idx;
    logic [ADDR_W-3:0] word_idx;
    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00) && (word_idx <= (ADDR_W-2)'(5));
    assign idx      = word_idx[2:0];

    logic wr_hit [6];
    logic rd_data_hit;
    always_comb begin
        for (int r = 0; r < 6; r++) begin
            wr_hit[r] = bus_wr && aligned && (idx == 3'(r));
        end
        rd_data_hit = bus_rd && aligned && (idx == IDX_DATA);
    end

    // registers
    logic [WORD_W-1:0] ctrl0_q;
    ctrl1_t            ctrl1_q;
    logic [7:0]        presc_q;

    for (genvar b = 0; b < LANES; b++) begin : g_ctrl0_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl0_q[8*b +: 8] <= '0;
            end else if (wr_hit[IDX_CTRL0] && bus_be[b]) begin
                ctrl0_q[8*b +: 8] <= bus_wdata[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl1_q <= '0;
            presc_q <= '0;
        end else begin
            if (wr_hit[IDX_CTRL1] && bus_be[0]) begin
                ctrl1_q <= ctrl1_t'(bus_wdata[6:0]);
            end
            if (wr_hit[IDX_PRESC] && bus_be[0]) begin
                presc_q <= {bus_wdata[7:1], 1'b0};
            end
        end
    end

    // transmit path
    logic [WORD_W-1:0] tx_word_in;
    for (genvar b = 0; b < LANES; b++) begin : g_tx_lane
        assign tx_word_in[8*b +: 8] = bus_be[b] ? bus_wdata[8*b +: 8] : 8'h00;
    end

    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [WORD_W-1:0] tx_head;
    logic [CNT_W-1:0]  tx_count;
    assign tx_push = wr_hit[IDX_DATA] && (|bus_be);

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .wdata(tx_word_in),
        .pop(tx_pop), .head(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    // receive path
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_word, rx_head;
    logic [CNT_W-1:0]  rx_count;
    assign rx_pop = rd_data_hit && !rx_empty;

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .head(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    // serial side stand-in
    logic overrun_evt, sh_busy;
    ssp_shift_model #(.XFER_CYCLES(XFER_CYCLES)) u_shift (
        .clk(clk), .rst(rst),
        .enable(ctrl1_q.port_on), .loopback(ctrl1_q.loop_back),
        .size_m1(ctrl0_q[SIZE_W-1:0]),
        .tx_empty(tx_empty), .tx_head(tx_head),
        .rx_full(rx_full), .far_word(far_rx_word),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .overrun_evt(overrun_evt), .busy(sh_busy)
    );

    // interrupts
    isr_t irq_en, isr_raw;
    logic ovr_flag, isr_clear;
    assign irq_en    = '{ovr: ctrl1_q.ovr_ie, txq: ctrl1_q.txq_ie, rxq: ctrl1_q.rxq_ie};
    assign isr_clear = wr_hit[IDX_ISR];

    ssp_irq_ctl #(.DEPTH(FIFO_DEPTH)) u_irq (
        .clk(clk), .rst(rst),
        .tx_count(tx_count), .rx_count(rx_count),
        .overrun_evt(overrun_evt), .clear(isr_clear),
        .enables(irq_en), .raw(isr_raw), .ovr_flag(ovr_flag), .irq(irq)
    );

    // read mux
    stat_t stat;
    assign stat = '{busy: sh_busy, rx_full: rx_full, rx_some: !rx_empty,
                    tx_room: !tx_full, tx_empty: tx_empty};

    logic [WORD_W-1:0] rd_val;
    always_comb begin
        rd_val = '0;
        if (aligned) begin
            case (idx)
                IDX_CTRL0: rd_val = ctrl0_q;
                IDX_CTRL1: rd_val = WORD_W'(ctrl1_q);
                IDX_DATA:  rd_val = rx_empty ? '0 : rx_head;
                IDX_STAT:  rd_val = WORD_W'(stat);
                IDX_PRESC: rd_val = WORD_W'(presc_q);
                IDX_ISR:   rd_val = WORD_W'(isr_raw);
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/ssp_regif_chk.sv
module ssp_regif_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_push,
    input logic             tx_full,
    input logic             tx_pop,
    input logic [CNT_W-1:0] tx_count,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [CNT_W-1:0] rx_count,
    input logic             overrun_evt,
    input logic             isr_clear,
    input logic             ovr_flag,
    input logic             port_on,
    input logic             presc_lsb,
    input logic [2:0]       irq_en,
    input logic             irq
);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full && !tx_pop) |=> (tx_count == $past(tx_count)));

    assert_rx_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_push) |=> (rx_count == $past(rx_count) - 1'b1));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !port_on |-> !tx_pop);

    assert_presc_even_R3: assert property (@(posedge clk) disable iff (rst)
        !presc_lsb);

    assert_ovr_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(overrun_evt));

    assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (isr_clear && !overrun_evt) |=> !ovr_flag);

    assert_ovr_drop_R10: assert property (@(posedge clk) disable iff (rst)
        overrun_evt |-> !rx_push);

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 3'b000) |-> !irq);
endmodule

bind ssp_regif ssp_regif_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst),
    .tx_push(tx_push), .tx_full(tx_full), .tx_pop(tx_pop), .tx_count(tx_count),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_count(rx_count),
    .overrun_evt(overrun_evt), .isr_clear(isr_clear), .ovr_flag(ovr_flag),
    .port_on(ctrl1_q.port_on), .presc_lsb(presc_q[0]),
    .irq_en(irq_en), .irq(irq)
);

// File: tb/sim_ssp_regif.sv
`timescale 1ns/1ps
module sim_ssp_regif;
    localparam logic [4:0] A_C0 = 5'h00, A_C1 = 5'h04, A_DAT = 5'h08,
                           A_ST = 5'h0C, A_PS = 5'h10, A_IS = 5'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] far_rx_word = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ssp_regif u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .far_rx_word(far_rx_word), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] fmask(input int sz_m1);
        return 16'(((32'd1 << (sz_m1 + 1)) - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0x0000 expected 0x0001");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_C0, d); check("R1 ctrl0", d, 16'h0000);
        rd(A_C1, d); check("R1 ctrl1", d, 16'h0000);
        rd(A_DAT, d); check("R1 data", d, 16'h0000);
        rd(A_ST, d); check("R1 status", d, 16'h0003);
        rd(A_PS, d); check("R1 prescale", d, 16'h0000);
        rd(A_IS, d); check("R1 isr", d, 16'h0002);
        check("R1 irq", 16'(irq), 16'h0000);

        // R2 byte lanes and register storage
        wr(A_C0, 16'hA5C3, 2'b11); rd(A_C0, d); check("R2 ctrl0 full", d, 16'hA5C3);
        wr(A_C0, 16'hFF12, 2'b01); rd(A_C0, d); check("R2 ctrl0 low lane", d, 16'hA512);
        wr(A_C0, 16'h7799, 2'b10); rd(A_C0, d); check("R2 ctrl0 high lane", d, 16'h7712);
        wr(A_C1, 16'hFF63, 2'b11); rd(A_C1, d); check("R2 ctrl1 width", d, 16'h0063);
        wr(A_C1, 16'h0000, 2'b10); rd(A_C1, d); check("R2 ctrl1 high lane only", d, 16'h0063);
        wr(A_C1, 16'h0000, 2'b01); rd(A_C1, d); check("R2 ctrl1 cleared", d, 16'h0000);

        // R3 prescale sweep
        for (int v = 0; v < 256; v += 17) begin
            wr(A_PS, 16'(v), 2'b01);
            rd(A_PS, d);
            check("R3 prescale even", d, 16'(v & 16'hFE));
        end

        // R4 R6 R9: fill TX with the port off, loopback on
        wr(A_C0, 16'h000F, 2'b11);
        wr(A_C1, 16'h0008, 2'b01);
        for (int k = 1; k <= 9; k++) begin
            wr(A_DAT, 16'h1000 + 16'(k), 2'b11);
            rd(A_ST, d);
            check("R6 status tx fill", d, {14'd0, (k < 8) ? 1'b1 : 1'b0, 1'b0});
            rd(A_IS, d);
            check("R9 tx request", 16'(d[1]), (k <= 4) ? 16'd1 : 16'd0);
        end
        // R8 port off holds everything
        repeat (100) @(negedge clk);
        rd(A_ST, d); check("R8 held while off", d, 16'h0000);

        wr(A_C1, 16'h0018, 2'b01);
        repeat (150) @(negedge clk);
        rd(A_ST, d); check("R6 rx full status", d, 16'h000F);
        rd(A_IS, d); check("R9 both requests", d, 16'h0003);
        for (int k = 1; k <= 8; k++) begin
            rd(A_DAT, d);
            check("R5 R4 rx order", d, 16'h1000 + 16'(k));
            rd(A_IS, d);
            check("R9 rx request", 16'(d[0]), ((8 - k) >= 4) ? 16'd1 : 16'd0);
        end
        rd(A_DAT, d); check("R5 empty read", d, 16'h0000);
        rd(A_ST, d); check("R5 status after empty read", d, 16'h0003);

        // R7 loopback across every frame size
        for (int s = 3; s <= 15; s++) begin
            logic [15:0] v;
            v = 16'hFFFF ^ 16'(s * 16'h0931);
            wr(A_C0, 16'(s), 2'b01);
            wr(A_DAT, v, 2'b11);
            repeat (20) @(negedge clk);
            rd(A_DAT, d);
            check("R7 loopback size", d, v & fmask(s));
        end

        // R7 far-side word, loopback off
        wr(A_C1, 16'h0010, 2'b01);
        far_rx_word = 16'h5A3C;
        for (int s = 3; s <= 15; s += 4) begin
            wr(A_C0, 16'(s), 2'b01);
            wr(A_DAT, 16'h0F0F, 2'b11);
            repeat (20) @(negedge clk);
            rd(A_DAT, d);
            check("R7 far word", d, 16'h5A3C & fmask(s));
        end

        // R10 R11 overrun and masking
        wr(A_C0, 16'h000F, 2'b01);
        wr(A_C1, 16'h0018, 2'b01);
        for (int k = 1; k <= 9; k++) begin
            wr(A_DAT, 16'h2000 + 16'(k), 2'b11);
        end
        repeat (150) @(negedge clk);
        rd(A_IS, d); check("R10 overrun set", d, 16'h0007);
        for (int e = 0; e < 8; e++) begin
            wr(A_C1, 16'h0018 | 16'(e), 2'b01);
            check("R11 irq mask sweep", 16'(irq), (e != 0) ? 16'd1 : 16'd0);
        end
        wr(A_IS, 16'h0000, 2'b01);
        rd(A_IS, d); check("R10 overrun cleared", d, 16'h0003);
        wr(A_C1, 16'h001C, 2'b01);
        check("R11 irq after clear", 16'(irq), 16'h0000);
        for (int k = 1; k <= 8; k++) begin
            rd(A_DAT, d);
            check("R10 dropped frame absent", d, 16'h2000 + 16'(k));
        end
        rd(A_ST, d); check("R10 rx empty after drain", d, 16'h0003);
        wr(A_C1, 16'h0019, 2'b01);
        check("R11 rx source low", 16'(irq), 16'h0000);
        wr(A_C1, 16'h001A, 2'b01);
        check("R11 tx source high", 16'(irq), 16'h0001);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule